// File: doc/BRIEF.md
# UART Byte Buffer with Fill-Level Flags

This block sits between a register bus and the serial shifters of a UART. It holds two independent 16-entry byte queues: one carries bytes written by software towards the transmit shifter, the other carries bytes assembled by the receive shifter towards software. Software pushes transmit bytes and pops receive bytes through a four-word register window. The shifters use single-cycle push and pop strobes. A pop from an empty queue returns the last byte that left that queue.

Each queue has a selectable fill threshold and a sticky flag. The receive flag is raised when the receive queue holds at least its threshold. The transmit flag is raised when the transmit queue holds no more than its threshold. A third threshold drives an active-low request-to-send output when hardware flow control is on. A loopback switch routes the transmit shifter's serial output into the receive shifter's serial input.

Register window (2-bit address): 0 = control, 1 = flags, 2 = fill levels, 3 = data. Control fields: [10:8] flow-control threshold select, [7:6] receive threshold select, [5:4] transmit threshold select, [3] flow-control enable, [2] transmit queue clear (write-only strobe, reads 0), [1] receive queue clear (write-only strobe, reads 0), [0] loopback. Flags: [0] transmit-low, [1] receive-high, [2] transmit overflow, [3] receive overflow.

Top module: `uart_fifo_stage`

## Requirements
- R1: The receive-high flag (flags bit 1) is raised one cycle after the receive count is greater than or equal to the threshold chosen by control bits [7:6]: code 0 selects 1, code 1 selects 4, code 2 selects 8, code 3 selects 14.
- R2: The transmit-low flag (flags bit 0) is raised one cycle after the transmit count is less than or equal to the threshold chosen by control bits [5:4]: code 0 selects 8, code 1 selects 4, code 2 selects 2, code 3 selects 1.
- R3: Flags are sticky. Writing 0 to a flag bit at address 1 clears it only when its raising condition is false in that cycle. Writing 1 has no effect.
- R4: Writing control with bit 2 set empties the transmit queue. The receive queue is untouched.
- R5: Writing control with bit 1 set empties the receive queue. The transmit queue is untouched.
- R6: Address 2 reads the transmit count in bits [12:8] and the receive count in bits [4:0], each from 0 to 16. Other bits read 0.
- R7: Both queues are first-in first-out. A write to address 3 pushes a transmit byte, and the transmit shifter's pop strobe takes bytes in the same order. The receive shifter's push strobe enqueues bytes, and a read strobe at address 3 returns and removes them in the same order.
- R8: A push into a full queue is dropped and the count stays 16. The queue's overflow flag is set (bit 2 for transmit, bit 3 for receive). Writing 0 to that bit clears it.
- R9: A pop from an empty queue leaves the count at 0 and returns the last byte removed from that queue.
- R10: With control bit 3 set, `rtsN` is 1 while the receive count exceeds the threshold chosen by bits [10:8], and 0 otherwise. Codes 0 to 7 select 15, 1, 4, 6, 8, 10, 12, 14. With bit 3 clear, `rtsN` is 0.
- R11: With control bit 0 set, `rxSerialOut` follows `txSerialIn` and `txdPin` is held at 1. With it clear, `rxSerialOut` follows `rxdPin` and `txdPin` follows `txSerialIn`.
- R12: After reset both queues are empty, control reads 0, flags read 0x1 and `rtsN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive queue at address 3) |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data (combinational) |
| txShiftPop | input | 1 | Transmit shifter takes the head byte |
| txShiftData | output | 8 | Transmit head byte, or the last byte taken when empty |
| txShiftAvail | output | 1 | Transmit queue is not empty |
| rxShiftPush | input | 1 | Receive shifter delivers a byte |
| rxShiftData | input | 8 | Byte from the receive shifter |
| txSerialIn | input | 1 | Serial output of the transmit shifter |
| txdPin | output | 1 | Serial line towards the pad |
| rxdPin | input | 1 | Serial line from the pad |
| rxSerialOut | output | 1 | Serial input to the receive shifter |
| rtsN | output | 1 | Active-low request-to-send |

## Verification
The properties assume that reset is applied before traffic starts. They also assume that the register strobes are only meaningful together with a stable `regAddr` in the same cycle, and that a queue clear is not combined with a push into a full queue in the overflow properties. The stimulus issues at most one register action per cycle, so a read-pop and a write-push never meet on the data address. Shifter strobes and register actions are mixed freely. This includes pops on empty queues and pushes on full queues, which the design defines rather than excludes.

// File: rtl/uart_fifo_stage_pkg.sv
package uart_fifo_stage_pkg;

  localparam int REG_W = 16;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_FLAGS = 2'd1;
  localparam logic [1:0] ADDR_LEVEL = 2'd2;
  localparam logic [1:0] ADDR_DATA  = 2'd3;

  // stored control fields
  typedef struct packed {
    logic [2:0] rtsSel;
    logic [1:0] rxTrigSel;
    logic [1:0] txTrigSel;
    logic       modemEn;
    logic       loopEn;
  } fifoCfg_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } dpStrobe_t;

  // order matches the flag register, bit 3 down to bit 0
  typedef struct packed {
    logic rxOvf;
    logic txOvf;
    logic rxHigh;
    logic txLow;
  } flagVec_t;

  function automatic int rxTrigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int txTrigLevel(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 4;
      2'd2:    return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int rtsLevel(input logic [2:0] sel);
    case (sel)
      3'd0:    return 15;
      3'd1:    return 1;
      3'd2:    return 4;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      3'd6:    return 12;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/ufs_ring.sv
module ufs_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count,
  output logic              pushDropped
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] lastData;
  logic              full, empty, doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full        = (count == CNT_W'(DEPTH));
  assign empty       = (count == '0);
  assign doPush      = push & ~full & ~flush;
  assign doPop       = pop & ~empty & ~flush;
  assign pushDropped = push & full & ~flush;
  assign headData    = empty ? lastData : mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      lastData <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop) begin
        rdPtr    <= nextPtr(rdPtr);
        lastData <= mem[rdPtr];
      end
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

endmodule

// File: rtl/ufs_datapath.sv
module ufs_datapath
  import uart_fifo_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              loopEn,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txShiftPop,
  output logic [DATA_W-1:0] txShiftData,
  input  logic              rxShiftPush,
  input  logic [DATA_W-1:0] rxShiftData,
  output logic [DATA_W-1:0] rxHeadData,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txDropped,
  output logic              rxDropped,
  input  logic              txSerialIn,
  input  logic              rxdPin,
  output logic              txdPin,
  output logic              rxSerialOut
);

  // index 0 = transmit queue, index 1 = receive queue
  localparam int NUM_RING = 2;

  logic [NUM_RING-1:0] ringFlush, ringPush, ringPop, ringDrop;
  logic [DATA_W-1:0]   ringIn   [NUM_RING];
  logic [DATA_W-1:0]   ringHead [NUM_RING];
  logic [CNT_W-1:0]    ringCnt  [NUM_RING];

  assign ringFlush = {strobe.rxFlush, strobe.txFlush};
  assign ringPush  = {rxShiftPush, strobe.txPush};
  assign ringPop   = {strobe.rxPop, txShiftPop};
  assign ringIn[0] = txPushData;
  assign ringIn[1] = rxShiftData;

  for (genvar g = 0; g < NUM_RING; g++) begin : g_ring
    ufs_ring #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
    ) u_ring (
      .clk         (clk),
      .rstN        (rstN),
      .flush       (ringFlush[g]),
      .push        (ringPush[g]),
      .pushData    (ringIn[g]),
      .pop         (ringPop[g]),
      .headData    (ringHead[g]),
      .count       (ringCnt[g]),
      .pushDropped (ringDrop[g])
    );
  end

  assign txShiftData = ringHead[0];
  assign rxHeadData  = ringHead[1];
  assign txCount     = ringCnt[0];
  assign rxCount     = ringCnt[1];
  assign txDropped   = ringDrop[0];
  assign rxDropped   = ringDrop[1];

  // loopback: the line stays at mark while the shifter talks to itself
  assign txdPin      = loopEn ? 1'b1 : txSerialIn;
  assign rxSerialOut = loopEn ? txSerialIn : rxdPin;

endmodule

// File: rtl/ufs_ctrl.sv
module ufs_ctrl
  import uart_fifo_stage_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txDropped,
  input  logic             rxDropped,
  output dpStrobe_t        strobe,
  output fifoCfg_t         cfg,
  output flagVec_t         flags,
  output logic             rtsN
);

  logic wrCtrl, wrFlags;
  logic txCond, rxCond;
  logic unusedHighBits;

  assign unusedHighBits = ^regWrData[REG_W-1:11];

  assign wrCtrl  = regWrEn & (regAddr == ADDR_CTRL);
  assign wrFlags = regWrEn & (regAddr == ADDR_FLAGS);

  assign strobe.txPush  = regWrEn & (regAddr == ADDR_DATA);
  assign strobe.rxPop   = regRdEn & (regAddr == ADDR_DATA);
  assign strobe.txFlush = wrCtrl & regWrData[2];
  assign strobe.rxFlush = wrCtrl & regWrData[1];

  assign txCond = int'(txCount) <= txTrigLevel(cfg.txTrigSel);
  assign rxCond = int'(rxCount) >= rxTrigLevel(cfg.rxTrigSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrCtrl) begin
      cfg.rtsSel    <= regWrData[10:8];
      cfg.rxTrigSel <= regWrData[7:6];
      cfg.txTrigSel <= regWrData[5:4];
      cfg.modemEn   <= regWrData[3];
      cfg.loopEn    <= regWrData[0];
    end
  end

  // a set condition always wins over a software clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '{rxOvf: 1'b0, txOvf: 1'b0, rxHigh: 1'b0, txLow: 1'b1};
    end else begin
      flags.txLow  <= txCond    | (flags.txLow  & ~(wrFlags & ~regWrData[0]));
      flags.rxHigh <= rxCond    | (flags.rxHigh & ~(wrFlags & ~regWrData[1]));
      flags.txOvf  <= txDropped | (flags.txOvf  & ~(wrFlags & ~regWrData[2]));
      flags.rxOvf  <= rxDropped | (flags.rxOvf  & ~(wrFlags & ~regWrData[3]));
    end
  end

  assign rtsN = cfg.modemEn & (int'(rxCount) > rtsLevel(cfg.rtsSel));

endmodule

// File: rtl/uart_fifo_stage.sv
module uart_fifo_stage
  import uart_fifo_stage_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              txShiftPop,
  output logic [DATA_W-1:0] txShiftData,
  output logic              txShiftAvail,
  input  logic              rxShiftPush,
  input  logic [DATA_W-1:0] rxShiftData,
  input  logic              txSerialIn,
  output logic              txdPin,
  input  logic              rxdPin,
  output logic              rxSerialOut,
  output logic              rtsN
);

  dpStrobe_t         strobe;
  fifoCfg_t          cfg;
  flagVec_t          flags;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic              txDropped, rxDropped;
  logic [DATA_W-1:0] rxHeadData;

  ufs_ctrl #(
    .DEPTH (DEPTH)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .txDropped (txDropped),
    .rxDropped (rxDropped),
    .strobe    (strobe),
    .cfg       (cfg),
    .flags     (flags),
    .rtsN      (rtsN)
  );

  ufs_datapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .loopEn      (cfg.loopEn),
    .txPushData  (regWrData[DATA_W-1:0]),
    .txShiftPop  (txShiftPop),
    .txShiftData (txShiftData),
    .rxShiftPush (rxShiftPush),
    .rxShiftData (rxShiftData),
    .rxHeadData  (rxHeadData),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .txDropped   (txDropped),
    .rxDropped   (rxDropped),
    .txSerialIn  (txSerialIn),
    .rxdPin      (rxdPin),
    .txdPin      (txdPin),
    .rxSerialOut (rxSerialOut)
  );

  assign txShiftAvail = (txCount != '0);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[10:8] = cfg.rtsSel;
        regRdData[7:6]  = cfg.rxTrigSel;
        regRdData[5:4]  = cfg.txTrigSel;
        regRdData[3]    = cfg.modemEn;
        regRdData[0]    = cfg.loopEn;
      end
      ADDR_FLAGS: regRdData[3:0] = flags;
      ADDR_LEVEL: begin
        regRdData[8 +: CNT_W] = txCount;
        regRdData[0 +: CNT_W] = rxCount;
      end
      default: regRdData[DATA_W-1:0] = rxHeadData;
    endcase
  end

endmodule

// File: rtl/uart_fifo_stage_chk.sv
module uart_fifo_stage_chk
  import uart_fifo_stage_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txShiftPop,
  input logic             rxShiftPush,
  input dpStrobe_t        strobe,
  input logic [1:0]       rxTrigSel,
  input logic [1:0]       txTrigSel,
  input flagVec_t         flags,
  input logic             rxHighClr,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount
);

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txCount) <= DEPTH) && (int'(rxCount) <= DEPTH));

  // R4
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.txFlush |=> (txCount == '0));

  // R5
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rxFlush |=> (rxCount == '0));

  // R8
  tx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txCount) == DEPTH && strobe.txPush && !txShiftPop && !strobe.txFlush)
      |=> (int'(txCount) == DEPTH && flags.txOvf));

  // R8
  rx_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rxCount) == DEPTH && rxShiftPush && !strobe.rxPop && !strobe.rxFlush)
      |=> (int'(rxCount) == DEPTH && flags.rxOvf));

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && strobe.rxPop && !rxShiftPush) |=> (rxCount == '0));

  // R1
  rx_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rxCount) >= rxTrigLevel(rxTrigSel)) |=> flags.rxHigh);

  // R2
  tx_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txCount) <= txTrigLevel(txTrigSel)) |=> flags.txLow);

  // R3
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flags.rxHigh && !rxHighClr) |=> flags.rxHigh);

endmodule

bind uart_fifo_stage uart_fifo_stage_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txShiftPop  (txShiftPop),
  .rxShiftPush (rxShiftPush),
  .strobe      (strobe),
  .rxTrigSel   (cfg.rxTrigSel),
  .txTrigSel   (cfg.txTrigSel),
  .flags       (flags),
  .rxHighClr   (regWrEn && regAddr == 2'd1 && !regWrData[1]),
  .txCount     (txCount),
  .rxCount     (rxCount)
);

// File: tb/uart_fifo_stage_bench.sv
module uart_fifo_stage_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        txShiftPop = 1'b0;
  logic [7:0]  txShiftData;
  logic        txShiftAvail;
  logic        rxShiftPush = 1'b0;
  logic [7:0]  rxShiftData = '0;
  logic        txSerialIn = 1'b1, rxdPin = 1'b1;
  logic        txdPin, rxSerialOut, rtsN;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  uart_fifo_stage u_uart_fifo_stage (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regRdEn      (regRdEn),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .txShiftPop   (txShiftPop),
    .txShiftData  (txShiftData),
    .txShiftAvail (txShiftAvail),
    .rxShiftPush  (rxShiftPush),
    .rxShiftData  (rxShiftData),
    .txSerialIn   (txSerialIn),
    .txdPin       (txdPin),
    .rxdPin       (rxdPin),
    .rxSerialOut  (rxSerialOut),
    .rtsN         (rtsN)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] txLast, rxLast;
  bit mTxLow, mRxHigh, mTxOvf, mRxOvf;
  logic [1:0] mTxSel, mRxSel;

  function automatic int rxThr(input logic [1:0] s);
    int t[4] = '{1, 4, 8, 14};
    return t[s];
  endfunction

  function automatic int txThr(input logic [1:0] s);
    int t[4] = '{8, 4, 2, 1};
    return t[s];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic cpuPop(output logic [7:0] v);
    regAddr = 2'd3; regRdEn = 1'b1;
    #1 v = regRdData[7:0];
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic shPush(input logic [7:0] d);
    rxShiftPush = 1'b1; rxShiftData = d;
    @(negedge clk);
    rxShiftPush = 1'b0;
  endtask

  task automatic shPop(output logic [7:0] v);
    txShiftPop = 1'b1;
    #1 v = txShiftData;
    @(negedge clk);
    txShiftPop = 1'b0;
  endtask

  // one random cycle, checked against the model and then applied to it
  task automatic step(input int cpuOp, input logic [7:0] d, input bit sPop,
                      input bit sPush, input logic [7:0] rd, input bit readLvl);
    int txSz = txQ.size();
    int rxSz = rxQ.size();
    bit nTxLow, nRxHigh;
    logic [7:0] ex;
    regWrEn = (cpuOp == 1); regRdEn = (cpuOp == 2);
    regAddr = (cpuOp != 0) ? 2'd3 : (readLvl ? 2'd2 : 2'd1);
    regWrData = {8'h00, d};
    txShiftPop = sPop; rxShiftPush = sPush; rxShiftData = rd;
    #1;
    if (cpuOp == 2) begin
      ex = (rxSz > 0) ? rxQ[0] : rxLast;
      chk("R7 rx pop data", regRdData[7:0], ex);
    end else if (cpuOp == 0 && readLvl) begin
      chk("R6 level register", regRdData, (txSz << 8) | rxSz);
    end else if (cpuOp == 0) begin
      chk("R3 flags", regRdData, {mRxOvf, mTxOvf, mRxHigh, mTxLow});
    end
    if (sPop) begin
      ex = (txSz > 0) ? txQ[0] : txLast;
      chk("R7 tx pop data", txShiftData, ex);
    end
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0; txShiftPop = 1'b0; rxShiftPush = 1'b0;
    nTxLow  = mTxLow  | (txSz <= txThr(mTxSel));
    nRxHigh = mRxHigh | (rxSz >= rxThr(mRxSel));
    if (cpuOp == 1) begin
      if (txSz < 16) txQ.push_back(d); else mTxOvf = 1;
    end
    if (sPop && txSz > 0) txLast = txQ.pop_front();
    if (sPush) begin
      if (rxSz < 16) rxQ.push_back(rd); else mRxOvf = 1;
    end
    if (cpuOp == 2 && rxSz > 0) rxLast = rxQ.pop_front();
    mTxLow = nTxLow; mRxHigh = nRxHigh;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    peek(2'd2, v); chk("R12 level after reset", v, 0);
    peek(2'd1, v); chk("R12 flags after reset", v, 16'h0001);
    peek(2'd0, v); chk("R12 control after reset", v, 0);
    chk("R12 rtsN after reset", rtsN, 0);
    chk("R12 tx empty after reset", txShiftAvail, 0);

    // R2 / R3 transmit threshold 1 (code 3)
    wr(2'd0, 16'h0030);
    wr(2'd3, 16'h0011);
    wr(2'd3, 16'h0022);
    idle(2);
    peek(2'd1, v); chk("R3 tx flag still set", v[0], 1);
    wr(2'd1, 16'h000E); idle(1);
    peek(2'd1, v); chk("R3 tx flag cleared above threshold", v[0], 0);
    shPop(b); chk("R7 tx first byte", b, 8'h11);
    idle(2);
    peek(2'd1, v); chk("R2 tx flag at count 1", v[0], 1);
    wr(2'd1, 16'h000E); idle(1);
    peek(2'd1, v); chk("R3 clear ignored while condition holds", v[0], 1);

    // R1 receive threshold 4 (code 1), with receive clear
    wr(2'd0, 16'h0042);
    wr(2'd1, 16'h000D);
    for (int i = 1; i <= 3; i++) shPush(8'hA0 + 8'(i));
    idle(2);
    peek(2'd1, v); chk("R1 rx flag below threshold", v[1], 0);
    shPush(8'hA4);
    idle(2);
    peek(2'd1, v); chk("R1 rx flag at threshold", v[1], 1);
    for (int i = 1; i <= 4; i++) begin
      cpuPop(b); chk("R7 rx order", b, 8'hA0 + 8'(i));
    end
    idle(2);
    peek(2'd1, v); chk("R3 rx flag sticky when empty", v[1], 1);
    wr(2'd1, 16'h000D); idle(1);
    peek(2'd1, v); chk("R3 rx flag cleared", v[1], 0);

    // R9 pop from empty receive queue
    cpuPop(b); chk("R9 empty pop returns last", b, 8'hA4);
    peek(2'd2, v); chk("R9 rx count stays 0", v[4:0], 0);

    // R10 flow control, threshold 4 (code 2)
    wr(2'd0, 16'h0208);
    for (int i = 1; i <= 4; i++) shPush(8'hB0 + 8'(i));
    #1 chk("R10 rtsN at threshold", rtsN, 0);
    shPush(8'hB5);
    #1 chk("R10 rtsN above threshold", rtsN, 1);
    wr(2'd0, 16'h0200);
    #1 chk("R10 rtsN with control off", rtsN, 0);

    // R5 receive clear leaves transmit queue alone
    wr(2'd0, 16'h0002);
    peek(2'd2, v); chk("R5 rx cleared, tx kept", v, 16'h0100);

    // R4 transmit clear, R8 overflow
    wr(2'd0, 16'h0004);
    peek(2'd2, v); chk("R4 tx cleared", v, 0);
    for (int i = 0; i < 17; i++) wr(2'd3, 16'h0080 + 16'(i));
    peek(2'd2, v); chk("R8 tx count saturates", v, 16'h1000);
    peek(2'd1, v); chk("R8 tx overflow flag", v[2], 1);
    for (int i = 0; i < 16; i++) begin
      shPop(b); chk("R7 tx order after overflow", b, 8'h80 + 8'(i));
    end
    #1 chk("R9 tx empty", txShiftAvail, 0);
    shPop(b); chk("R9 tx empty pop returns last", b, 8'h8F);
    peek(2'd2, v); chk("R9 tx count stays 0", v, 0);
    wr(2'd1, 16'h000B); idle(1);
    peek(2'd1, v); chk("R8 tx overflow cleared", v[2], 0);

    // R11 loopback
    txSerialIn = 1'b0; rxdPin = 1'b1;
    #1 chk("R11 txd passthrough", txdPin, 0);
    chk("R11 rxd passthrough", rxSerialOut, 1);
    wr(2'd0, 16'h0001);
    #1 chk("R11 txd held at mark", txdPin, 1);
    chk("R11 loop routes tx to rx", rxSerialOut, 0);
    txSerialIn = 1'b1; rxdPin = 1'b0;
    #1 chk("R11 loop follows tx, ignores rxd", rxSerialOut, 1);

    // constrained random traffic
    mTxSel = 2'($urandom_range(0, 3));
    mRxSel = 2'($urandom_range(0, 3));
    wr(2'd0, {8'h00, mRxSel, mTxSel, 4'b0110});
    wr(2'd1, 16'h0000);
    txQ.delete(); rxQ.delete();
    txLast = 8'h8F; rxLast = 8'hA4;
    mTxLow = 1; mRxHigh = 0; mTxOvf = 0; mRxOvf = 0;
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 9));
      int op = (r < 4) ? 1 : ((r < 7) ? 2 : 0);
      step(op, 8'($urandom), ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 4),
           8'($urandom), n[0]);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule